// File: doc/BRIEF.md
# I2C Master Byte Transfer Sequencer

This block is the byte-level control engine of an I2C master. Software-facing logic hands it a control word and a byte count. From these it drives an abstract byte-level bus agent with four commands: start plus address, send a byte, receive a byte, and stop. It keeps one command in flight at a time and collects the acknowledge that comes back with each byte. A four-byte holding buffer stages outgoing bytes from the host and incoming bytes from the bus. The sequencer reports transmit-ready, receive-ready, access-ready and no-acknowledge events to the surrounding status logic.

Two transfer styles are supported. In counted mode a working count is loaded at start and decremented per byte. When it reaches zero the transfer ends: a stop is sent only if the stop bit is set at that moment, and access-ready is raised while master mode drops either way. In repeat mode the count is ignored. Bytes move for as long as data or buffer space exists, and writing the stop bit ends the transfer.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the control readback, working count, busy flag, command valid, both ready flags and the buffer level are all zero.
- R2: A control write stores the written value ANDed with 0xCF86. The start bit (bit 0) acts as a command and always reads back as 0. Bit positions: enable 15, byte swap 14, master 10, transmit 9, extended address 8, repeat 2, stop 1, start 0.
- R3: While idle, a control write with enable, master and start set and extended address clear issues command START (code 0) with data {slave_addr, ~transmit}. It also loads the working count from the count register. An acknowledged start sets busy.
- R4: A start that is not acknowledged pulses nack_evt, leaves busy clear and issues nothing further.
- R5: A control write that sets enable and start with master clear, or with extended address set, is stored but issues no command.
- R6: In counted transmit mode, buffered bytes are sent in push order as SEND (code 1) while the count is nonzero, and each send decrements the count. After each acknowledged send, xrdy equals (count still nonzero). A host push clears xrdy.
- R7: In counted receive mode, RECV (code 2) is issued while the count is nonzero and the buffer holds fewer than 4 bytes. Each received byte is buffered, decrements the count and sets rrdy. rx_pop removes bytes oldest first, and rrdy clears when the last byte leaves.
- R8: At count zero with the stop bit set, STOP (code 3) is issued. When it completes, busy, stop and master clear, the count reloads from the count register and ardy_evt pulses once.
- R9: At count zero with the stop bit clear, no STOP is issued, ardy_evt pulses once, master clears and busy stays set. A later write with enable and stop set then issues the STOP.
- R10: In repeat mode the working count never changes. A set stop bit issues STOP, after which ardy_evt pulses and master clears. In transmit, xrdy is set, and in receive, reception continues while the buffer has space.
- R11: A data byte that is not acknowledged pulses nack_evt, clears the stop bit and issues no further command.
- R12: A control write with enable clear drops busy and issues no new command. An outstanding command is allowed to complete. Data commands are only issued while busy.
- R13: The holding buffer keeps at most 4 bytes. A host push into a full buffer is ignored.
- R14: A command stays valid with stable code and data until bus_done, and is withdrawn the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word value |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | CW | Byte count value |
| slave_addr | input | DW-1 | Target 7-bit address |
| tx_push | input | 1 | Push one outgoing byte into the buffer |
| tx_byte | input | DW | Outgoing byte |
| rx_pop | input | 1 | Remove the oldest buffered byte |
| rx_byte | output | DW | Oldest buffered byte |
| buf_level | output | LW | Bytes held in the buffer |
| bus_cmd_valid | output | 1 | Command to bus agent is pending |
| bus_cmd | output | 2 | Command code: 0 start, 1 send, 2 receive, 3 stop |
| bus_cmd_data | output | DW | Address byte or data byte |
| bus_done | input | 1 | Agent completed the pending command |
| bus_ack | input | 1 | Acknowledge result for start or send |
| bus_rdata | input | DW | Received byte on a receive completion |
| ctrl_q | output | 16 | Current control word |
| count_cur | output | CW | Working byte count |
| bus_busy | output | 1 | Bus held by this master |
| xrdy | output | 1 | Transmit-ready |
| rrdy | output | 1 | Receive-ready |
| ardy_evt | output | 1 | Access-ready one-cycle pulse |
| nack_evt | output | 1 | No-acknowledge one-cycle pulse |

## Verification
A wrong working count shows up at the command port within one byte time. It appears as one SEND or RECV too many or too few before the STOP, or as a count_cur value after reload that differs from the programmed one. A stale stop or master bit shows in ctrl_q on the cycle after the stop completes, and also as a missing or duplicated STOP in the command log. A buffer pointer fault reorders or drops bytes, and this is visible at bus_cmd_data on the next SEND or at rx_byte on the next pop. The bench sweeps counts 1 to 4 in both directions and runs past the buffer capacity, so each of these faults reaches a compared value within a few commands.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_SEND  = 2'd1,
    BC_RECV  = 2'd2,
    BC_STOP  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP, S_ABORT
  } seq_state_e;

  localparam int B_EN   = 15;
  localparam int B_SWAP = 14;
  localparam int B_MST  = 10;
  localparam int B_TRX  = 9;
  localparam int B_XA   = 8;
  localparam int B_RM   = 2;
  localparam int B_STP  = 1;
  localparam int B_STT  = 0;

  localparam logic [15:0] CTRL_KEEP  = 16'hCF87;
  localparam logic [15:0] CTRL_STORE = CTRL_KEEP & ~(16'h0001 << B_STT);
endpackage

// File: rtl/i2c_hold_buf.sv
module i2c_hold_buf #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [15:0]   ctrl_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [DW-2:0] slave_addr,
  input  logic          tx_push,
  input  logic          rx_pop,
  input  logic [DW-1:0] buf_head,
  input  logic [LW-1:0] buf_level,
  input  logic          buf_empty,
  input  logic          buf_full,
  output logic          buf_pop_eng,
  output logic          buf_push_eng,
  output logic          bus_cmd_valid,
  output logic [1:0]    bus_cmd,
  output logic [DW-1:0] bus_cmd_data,
  input  logic          bus_done,
  input  logic          bus_ack,
  output logic [15:0]   ctrl_q,
  output logic [CW-1:0] count_cur,
  output logic          bus_busy,
  output logic          xrdy,
  output logic          rrdy,
  output logic          ardy_evt,
  output logic          nack_evt
);
  seq_state_e    state;
  logic [CW-1:0] cnt_cfg;
  logic stop_go, send_go, recv_go, end_go, tx_idle_rpt, start_req, cmd_open;
  logic rm, stp, trx;

  assign rm  = ctrl_q[B_RM];
  assign stp = ctrl_q[B_STP];
  assign trx = ctrl_q[B_TRX];

  // next-action decision for the running transfer
  always_comb begin
    stop_go     = 1'b0;
    send_go     = 1'b0;
    recv_go     = 1'b0;
    end_go      = 1'b0;
    tx_idle_rpt = 1'b0;
    if (state == S_RUN) begin
      if (rm) begin
        stop_go     = stp;
        send_go     = !stp && trx && !buf_empty;
        recv_go     = !stp && !trx && !buf_full;
        tx_idle_rpt = !stp && trx && buf_empty;
      end else if (count_cur == '0) begin
        stop_go = stp;
        end_go  = !stp;
      end else begin
        send_go = trx && !buf_empty;
        recv_go = !trx && !buf_full;
      end
    end else if (state == S_IDLE) begin
      stop_go = bus_busy && ctrl_q[B_EN] && stp;
    end
  end

  assign buf_pop_eng  = send_go;
  assign buf_push_eng = (state == S_RECV) && bus_done;
  assign start_req    = ctrl_wr && (state == S_IDLE) && ctrl_wdata[B_EN] &&
                        ctrl_wdata[B_MST] && !ctrl_wdata[B_XA] && ctrl_wdata[B_STT];
  assign cmd_open     = bus_cmd_valid && !bus_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      ctrl_q        <= '0;
      cnt_cfg       <= '0;
      count_cur     <= '0;
      bus_busy      <= 1'b0;
      bus_cmd_valid <= 1'b0;
      bus_cmd       <= BC_START;
      bus_cmd_data  <= '0;
      xrdy          <= 1'b0;
      rrdy          <= 1'b0;
      ardy_evt      <= 1'b0;
      nack_evt      <= 1'b0;
    end else begin
      ardy_evt <= 1'b0;
      nack_evt <= 1'b0;
      if (cnt_wr)  cnt_cfg <= cnt_wdata;
      if (tx_push) xrdy <= 1'b0;
      if (rx_pop)  rrdy <= (buf_level > LW'(1));

      if (stop_go) begin
        bus_cmd_valid <= 1'b1;
        bus_cmd       <= BC_STOP;
        state         <= S_STOP;
      end
      if (send_go) begin
        bus_cmd_valid <= 1'b1;
        bus_cmd       <= BC_SEND;
        bus_cmd_data  <= buf_head;
        state         <= S_SEND;
      end
      if (recv_go) begin
        bus_cmd_valid <= 1'b1;
        bus_cmd       <= BC_RECV;
        state         <= S_RECV;
      end
      if (end_go) begin
        ardy_evt      <= 1'b1;
        ctrl_q[B_MST] <= 1'b0;
        state         <= S_IDLE;
      end
      if (tx_idle_rpt) xrdy <= 1'b1;

      if (bus_cmd_valid && bus_done) begin
        bus_cmd_valid <= 1'b0;
        case (state)
          S_START: begin
            bus_busy <= bus_ack;
            nack_evt <= !bus_ack;
            state    <= bus_ack ? S_RUN : S_IDLE;
          end
          S_SEND: begin
            if (!rm) count_cur <= count_cur - 1'b1;
            if (bus_ack) begin
              xrdy  <= rm || (count_cur != CW'(1));
              state <= S_RUN;
            end else begin
              xrdy          <= 1'b0;
              nack_evt      <= 1'b1;
              ctrl_q[B_STP] <= 1'b0;
              state         <= S_IDLE;
            end
          end
          S_RECV: begin
            if (!rm) count_cur <= count_cur - 1'b1;
            rrdy  <= 1'b1;
            state <= S_RUN;
          end
          S_STOP: begin
            bus_busy      <= 1'b0;
            ctrl_q[B_STP] <= 1'b0;
            ctrl_q[B_MST] <= 1'b0;
            count_cur     <= cnt_cfg;
            ardy_evt      <= 1'b1;
            state         <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end

      // register write has the last word
      if (ctrl_wr) begin
        ctrl_q <= ctrl_wdata & CTRL_STORE;
        if (!ctrl_wdata[B_EN]) begin
          bus_busy      <= 1'b0;
          bus_cmd_valid <= cmd_open;
          state         <= cmd_open ? S_ABORT : S_IDLE;
        end else if (start_req) begin
          bus_cmd_valid <= 1'b1;
          bus_cmd       <= BC_START;
          bus_cmd_data  <= {slave_addr, ~ctrl_wdata[B_TRX]};
          count_cur     <= cnt_cfg;
          state         <= S_START;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int DEPTH = 4,
  parameter int CW    = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [15:0]   ctrl_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [DW-2:0] slave_addr,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_byte,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_byte,
  output logic [LW-1:0] buf_level,
  output logic          bus_cmd_valid,
  output logic [1:0]    bus_cmd,
  output logic [DW-1:0] bus_cmd_data,
  input  logic          bus_done,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic [15:0]   ctrl_q,
  output logic [CW-1:0] count_cur,
  output logic          bus_busy,
  output logic          xrdy,
  output logic          rrdy,
  output logic          ardy_evt,
  output logic          nack_evt
);
  logic          eng_pop, eng_push, b_empty, b_full;
  logic [DW-1:0] b_head;

  i2c_hold_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (eng_push || tx_push),
    .push_data (eng_push ? bus_rdata : tx_byte),
    .pop       (eng_pop || rx_pop),
    .head      (b_head),
    .level     (buf_level),
    .empty     (b_empty),
    .full      (b_full)
  );

  assign rx_byte = b_head;

  i2c_seq_ctrl #(.CW(CW), .DW(DW), .LW(LW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .ctrl_wr       (ctrl_wr),
    .ctrl_wdata    (ctrl_wdata),
    .cnt_wr        (cnt_wr),
    .cnt_wdata     (cnt_wdata),
    .slave_addr    (slave_addr),
    .tx_push       (tx_push),
    .rx_pop        (rx_pop),
    .buf_head      (b_head),
    .buf_level     (buf_level),
    .buf_empty     (b_empty),
    .buf_full      (b_full),
    .buf_pop_eng   (eng_pop),
    .buf_push_eng  (eng_push),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd       (bus_cmd),
    .bus_cmd_data  (bus_cmd_data),
    .bus_done      (bus_done),
    .bus_ack       (bus_ack),
    .ctrl_q        (ctrl_q),
    .count_cur     (count_cur),
    .bus_busy      (bus_busy),
    .xrdy          (xrdy),
    .rrdy          (rrdy),
    .ardy_evt      (ardy_evt),
    .nack_evt      (nack_evt)
  );
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_wr,
  input logic          bus_cmd_valid,
  input logic [1:0]    bus_cmd,
  input logic [DW-1:0] bus_cmd_data,
  input logic          bus_done,
  input logic          bus_ack,
  input logic          bus_busy,
  input logic [15:0]   ctrl_q,
  input logic [CW-1:0] count_cur,
  input logic          nack_evt
);
  logic is_data;
  assign is_data = (bus_cmd == BC_SEND) || (bus_cmd == BC_RECV);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && !bus_done |=> bus_cmd_valid && $stable(bus_cmd) && $stable(bus_cmd_data)); // R14

  AST_CMD_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && bus_done |=> !bus_cmd_valid); // R14

  AST_DATA_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cmd_valid) && is_data |-> bus_busy); // R12

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && bus_done && bus_cmd == BC_STOP && !ctrl_wr
    |=> !bus_busy && !ctrl_q[B_STP] && !ctrl_q[B_MST]); // R8

  AST_START_REFUSED: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && bus_done && bus_cmd == BC_START && !bus_ack && !ctrl_wr
    |=> nack_evt && !bus_busy); // R4

  AST_RPT_COUNT_FIXED: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_RM] && bus_cmd_valid && bus_done && is_data && !ctrl_wr
    |=> $stable(count_cur)); // R10

  AST_DATA_NACK: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid && bus_done && bus_cmd == BC_SEND && !bus_ack && !ctrl_wr
    |=> nack_evt && !ctrl_q[B_STP] && !bus_cmd_valid); // R11
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.CW(CW), .DW(DW)) u_chk (.*);

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  localparam int CW = 8;
  localparam logic [15:0] EN  = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          XA  = 16'h0100, RM  = 16'h0004, STP = 16'h0002,
                          STT = 16'h0001;
  localparam logic [6:0] SA = 7'h5A;

  logic clk = 0, rst = 1;
  logic ctrl_wr = 0, cnt_wr = 0, tx_push = 0, rx_pop = 0;
  logic [15:0] ctrl_wdata = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte, bus_cmd_data, bus_rdata;
  logic [2:0] buf_level;
  logic bus_cmd_valid, bus_done, bus_ack;
  logic [1:0] bus_cmd;
  logic [15:0] ctrl_q;
  logic [CW-1:0] count_cur;
  logic bus_busy, xrdy, rrdy, ardy_evt, nack_evt;

  int n_chk = 0, n_bad = 0;
  int log_n = 0, nack_at = -1, n_ardy = 0, n_nack = 0;
  logic [1:0] lc [512];
  logic [7:0] ld [512];

  always #2.5 clk = ~clk;

  i2c_xfer_seq u_dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .slave_addr(SA),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
    .buf_level(buf_level), .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd),
    .bus_cmd_data(bus_cmd_data), .bus_done(bus_done), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .count_cur(count_cur),
    .bus_busy(bus_busy), .xrdy(xrdy), .rrdy(rrdy), .ardy_evt(ardy_evt),
    .nack_evt(nack_evt)
  );

  // byte-level bus agent model: completes each command one cycle after it appears
  assign bus_ack   = (log_n != nack_at);
  assign bus_rdata = 8'hA0 + 8'(log_n);
  always @(posedge clk) begin
    if (rst) bus_done <= 1'b0;
    else begin
      bus_done <= bus_cmd_valid && !bus_done;
      if (bus_cmd_valid && bus_done) begin
        lc[log_n & 511] <= bus_cmd;
        ld[log_n & 511] <= bus_cmd_data;
        log_n <= log_n + 1;
      end
      if (ardy_evt) n_ardy <= n_ardy + 1;
      if (nack_evt) n_nack <= n_nack + 1;
    end
  end

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr_ctrl(logic [15:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic wr_cnt(int v);
    @(negedge clk); cnt_wr = 1; cnt_wdata = CW'(v);
    @(negedge clk); cnt_wr = 0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_byte = b;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_chk(string rq, int exp);
    @(negedge clk); check(rq, rx_byte, exp); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic entry(string rq, int idx, int c, int d);
    check({rq, " cmd"}, lc[idx & 511], c);
    if (c != 3 && c != 2) check({rq, " data"}, ld[idx & 511], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base, a0, nk;
    settle(3);
    // R1 reset state
    check("R1 ctrl", ctrl_q, 0);
    check("R1 count", count_cur, 0);
    check("R1 busy", bus_busy, 0);
    check("R1 valid", bus_cmd_valid, 0);
    check("R1 rdy", {xrdy, rrdy}, 0);
    check("R1 level", buf_level, 0);
    @(negedge clk); rst = 0;
    settle(2);

    // R2 / R5 masking, and writes that must not start
    base = log_n;
    wr_ctrl(16'hFFFF); settle(10);
    check("R2 mask", ctrl_q, 16'hCF86);
    check("R5 xa no start", log_n - base, 0);
    wr_ctrl(EN | STT); settle(10);
    check("R5 no master", log_n - base, 0);
    check("R2 stt reads 0", ctrl_q, 16'h8000);
    wr_ctrl(0);

    // R6 R8 counted transmit sweep with stop
    for (int n = 1; n <= 4; n++) begin
      wr_cnt(n);
      for (int k = 0; k < n; k++) push(8'(16 * n + k));
      base = log_n; a0 = n_ardy;
      wr_ctrl(EN | MST | TRX | STP | STT); settle(40);
      check("R6 log len", log_n - base, n + 2);
      entry("R3 start", base, 0, {SA, 1'b0});
      for (int k = 0; k < n; k++) entry("R6 send", base + 1 + k, 1, 16 * n + k);
      entry("R8 stop", base + n + 1, 3, 0);
      check("R8 reload", count_cur, n);
      check("R8 busy", bus_busy, 0);
      check("R8 ctrl", ctrl_q, EN | TRX);
      check("R8 ardy", n_ardy - a0, 1);
      check("R6 xrdy end", xrdy, 0);
    end

    // R6 waiting for data, xrdy behaviour
    wr_cnt(3); push(8'h71); push(8'h72);
    base = log_n;
    wr_ctrl(EN | MST | TRX | STP | STT); settle(30);
    check("R6 partial len", log_n - base, 3);
    check("R6 xrdy mid", xrdy, 1);
    check("R6 count mid", count_cur, 1);
    push(8'h73);
    check("R6 push clears xrdy", xrdy, 0);
    settle(30);
    entry("R6 late send", base + 3, 1, 8'h73);
    entry("R8 late stop", base + 4, 3, 0);

    // R7 R9 counted receive sweep without stop
    for (int n = 1; n <= 4; n++) begin
      wr_cnt(n);
      base = log_n; a0 = n_ardy;
      wr_ctrl(EN | MST | STT); settle(40);
      check("R7 log len", log_n - base, n + 1);
      entry("R3 start rd", base, 0, {SA, 1'b1});
      for (int k = 0; k < n; k++) entry("R7 recv", base + 1 + k, 2, 0);
      check("R7 rrdy", rrdy, 1);
      check("R7 level", buf_level, n);
      check("R9 busy held", bus_busy, 1);
      check("R9 ctrl", ctrl_q, EN);
      check("R9 ardy", n_ardy - a0, 1);
      for (int k = 0; k < n; k++) pop_chk("R7 pop", 8'(8'hA0 + base + 1 + k));
      check("R7 rrdy clr", rrdy, 0);
      wr_ctrl(EN | STP); settle(20);
      check("R9 stop later", log_n - base, n + 2);
      entry("R9 stop", base + n + 1, 3, 0);
      check("R9 released", bus_busy, 0);
      check("R9 ardy2", n_ardy - a0, 2);
    end

    // R13 receive past buffer capacity
    wr_cnt(6); base = log_n;
    wr_ctrl(EN | MST | STT); settle(40);
    check("R13 stop at 4", log_n - base, 5);
    check("R13 level full", buf_level, 4);
    check("R13 count left", count_cur, 2);
    pop_chk("R13 pop1", 8'(8'hA0 + base + 1)); settle(20);
    check("R13 refill", log_n - base, 6);
    check("R13 count 1", count_cur, 1);
    pop_chk("R13 pop2", 8'(8'hA0 + base + 2)); settle(20);
    check("R13 done", log_n - base, 7);
    check("R13 count 0", count_cur, 0);
    for (int k = 3; k <= 6; k++) pop_chk("R13 order", 8'(8'hA0 + base + k));
    wr_ctrl(0);
    for (int k = 0; k < 5; k++) push(8'(8'hC0 + k));
    check("R13 push full ignored", buf_level, 4);
    for (int k = 0; k < 4; k++) pop_chk("R13 kept", 8'hC0 + k);

    // R10 repeat mode transmit
    wr_cnt(3); push(8'h41); push(8'h42);
    base = log_n; a0 = n_ardy;
    wr_ctrl(EN | MST | TRX | RM | STT); settle(30);
    check("R10 sends", log_n - base, 3);
    entry("R10 b0", base + 1, 1, 8'h41);
    entry("R10 b1", base + 2, 1, 8'h42);
    check("R10 count fixed", count_cur, 3);
    check("R10 xrdy", xrdy, 1);
    check("R10 busy", bus_busy, 1);
    push(8'h43); settle(20);
    entry("R10 b2", base + 3, 1, 8'h43);
    wr_ctrl(EN | MST | TRX | RM | STP); settle(20);
    entry("R10 stop", base + 4, 3, 0);
    check("R10 ctrl", ctrl_q, EN | TRX | RM);
    check("R10 ardy", n_ardy - a0, 1);
    check("R10 busy off", bus_busy, 0);

    // R10 repeat mode receive with count zero
    wr_cnt(0); base = log_n;
    wr_ctrl(EN | MST | RM | STT); settle(40);
    check("R10 rx ignores count", log_n - base, 5);
    check("R10 rx level", buf_level, 4);
    wr_ctrl(EN | MST | RM | STP); settle(20);
    entry("R10 rx stop", base + 5, 3, 0);
    for (int k = 1; k <= 4; k++) pop_chk("R10 rx data", 8'(8'hA0 + base + k));

    // R11 data nack, then R12 abort
    wr_cnt(3); push(8'h51); push(8'h52); push(8'h53);
    base = log_n; nk = n_nack; nack_at = base + 2;
    wr_ctrl(EN | MST | TRX | STP | STT); settle(30);
    check("R11 stops issuing", log_n - base, 3);
    check("R11 nack", n_nack - nk, 1);
    check("R11 stp cleared", ctrl_q, EN | MST | TRX);
    check("R11 count", count_cur, 1);
    check("R11 xrdy", xrdy, 0);
    nack_at = -1;
    wr_ctrl(0); settle(20);
    check("R12 busy off", bus_busy, 0);
    check("R12 no cmd", log_n - base, 3);
    pop_chk("R11 leftover", 8'h53);

    // R4 start refused
    wr_cnt(2); base = log_n; nk = n_nack; nack_at = base;
    wr_ctrl(EN | MST | STT); settle(20);
    check("R4 only start", log_n - base, 1);
    check("R4 nack", n_nack - nk, 1);
    check("R4 busy", bus_busy, 0);
    nack_at = -1;

    // R12 abort right after start
    base = log_n;
    wr_ctrl(EN | MST | STT); wr_ctrl(0); settle(20);
    check("R12 abort log", log_n - base, 1);
    check("R12 abort busy", bus_busy, 0);
    check("R12 abort valid", bus_cmd_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule